// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block forms the next program counter for a 32-bit load/store core. Each cycle it takes the current PC, a decoded control-transfer opcode, the two source register values, a 16-bit branch displacement and a 26-bit jump field. From these it picks among four ways of forming the target:

- sequential (PC+4)
- absolute from a register
- pseudodirect inside the current 256 MB region
- PC-relative

It also raises a taken flag. For the two linking jumps it asks for a register write of the return address.

The next-PC path is purely combinational. A parameter adds a PC register behind it that loads the chosen value on every clock and resets to a boot address. Decode, the register file, delay slots and prediction stay outside the block.

Top module: `npc_unit`

## Requirements
- R1: Opcode 1 (register jump) makes next_pc_o equal rs_val_i and drives taken_o high.
- R2: Opcode 2 (region jump) makes next_pc_o equal {bits 31..28 of PC+4, target_i, 2'b00} and drives taken_o high. The upper nibble therefore comes from PC+4, not from the PC itself.
- R3: Opcode 3 (linking register jump) makes next_pc_o equal rs_val_i. It also asserts link_we_o, sets link_rd_o to rd_i and sets link_val_o to PC+4.
- R4: Opcode 4 (linking region jump) forms next_pc_o as in R2. It also asserts link_we_o, sets link_rd_o to 31 and sets link_val_o to PC+4.
- R5: A taken branch gives next_pc_o = PC+4 + (sign-extended offset_i shifted left by two). A branch that is not taken gives PC+4. taken_o follows the branch outcome.
- R6: Opcode 5 (equal) is taken when rs_val_i equals rt_val_i. Opcode 6 (not equal) is taken when the two differ.
- R7: Opcodes 7, 8, 9 and 10 compare rs_val_i, read as signed, with zero. They are taken for >= 0, > 0, <= 0 and < 0 respectively.
- R8: link_we_o is high only for opcodes 3 and 4. For every other opcode, link_rd_o reads 0.
- R9: Opcode 0 and the unused codes 11 to 15 give next_pc_o = PC+4 and taken_o low.
- R10: When REG_PC is 1, pc_reg_o holds RESET_PC (default 32'hBFC0_0000) while rst_n is low. Otherwise it shows the next_pc_o value from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional PC register |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction |
| op_i | input | 4 | Decoded control-transfer opcode |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| rd_i | input | 5 | Link destination for the linking register jump |
| offset_i | input | 16 | Branch displacement in words |
| target_i | input | 26 | Region-jump word target |
| next_pc_o | output | 32 | Selected next PC |
| taken_o | output | 1 | Control transfer taken |
| link_we_o | output | 1 | Return-address write request |
| link_rd_o | output | 5 | Return-address destination index |
| link_val_o | output | 32 | Return address (PC+4) |
| pc_reg_o | output | 32 | Registered PC |

## Verification
Region jumps are driven from a PC just below a 256 MB boundary. That case separates taking the upper nibble from PC+4 from taking it from the PC. Branches use positive, negative and most-negative displacements, which exposes a missing or wrong sign extension and a base of PC instead of PC+4. The zero compares see 0, 1, -1, the largest positive and the most negative value, so every signed boundary and any unsigned misreading shows up. Opcode 0 and an unused code, each given operands that would satisfy a branch, confirm that nothing is taken or linked.

// File: rtl/npc_pkg.sv
// Package: shared opcode encoding for the next-PC unit.
// Assumes the decoder outside drives exactly these 4-bit codes.
package npc_pkg;

    typedef enum logic [3:0] {
        CT_NONE       = 4'd0,
        CT_JREG       = 4'd1,
        CT_JREGION    = 4'd2,
        CT_JREG_LINK  = 4'd3,
        CT_JRGN_LINK  = 4'd4,
        CT_BR_EQ      = 4'd5,
        CT_BR_NE      = 4'd6,
        CT_BR_GEZ     = 4'd7,
        CT_BR_GTZ     = 4'd8,
        CT_BR_LEZ     = 4'd9,
        CT_BR_LTZ     = 4'd10
    } ct_op_e;

endpackage

// File: rtl/npc_target_gen.sv
// Module: npc_target_gen
// Forms the three computed targets: sequential (PC+4), PC-relative branch
// target and pseudodirect region target.
// Assumes word-aligned instructions and TGT_W + 2 == REGION_BITS.
module npc_target_gen #(
    parameter int XLEN        = 32,
    parameter int OFF_W       = 16,
    parameter int TGT_W       = 26,
    parameter int REGION_BITS = 28
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [TGT_W-1:0] target_i,
    output logic [XLEN-1:0]  seq_pc_o,
    output logic [XLEN-1:0]  br_tgt_o,
    output logic [XLEN-1:0]  rgn_tgt_o
);
    localparam int              WORD_SHIFT = 2;
    localparam int              EXT_W      = XLEN - OFF_W - WORD_SHIFT;
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [XLEN-1:0] disp;

    // Sequential successor address.
    always_comb seq_pc_o = pc_i + INSN_BYTES;

    // Byte displacement: sign-extend the word offset, then scale by four.
    always_comb disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {WORD_SHIFT{1'b0}}};

    // PC-relative target measured from the sequential address.
    always_comb br_tgt_o = seq_pc_o + disp;

    // Region target: upper bits kept from PC+4, lower bits from the jump field.
    always_comb rgn_tgt_o = {seq_pc_o[XLEN-1:REGION_BITS], target_i, {WORD_SHIFT{1'b0}}};

endmodule

// File: rtl/npc_cond_eval.sv
// Module: npc_cond_eval
// Decides whether a conditional branch is taken. Equality branches compare
// both operands; zero compares treat rs as two's-complement signed.
// Assumes op_i is a valid code; non-branch codes yield 0.
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ct_op_e           op_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic [XLEN-1:0]  rt_val_i,
    output logic             is_branch_o,
    output logic             cond_o
);
    logic rs_neg;
    logic rs_zero;
    logic ops_equal;

    // Sign, zero and equality flags of the operands.
    always_comb begin
        rs_neg    = rs_val_i[XLEN-1];
        rs_zero   = (rs_val_i == '0);
        ops_equal = (rs_val_i == rt_val_i);
    end

    // Per-opcode branch condition.
    always_comb begin
        is_branch_o = 1'b1;
        cond_o      = 1'b0;
        unique case (op_i)
            CT_BR_EQ:  cond_o = ops_equal;
            CT_BR_NE:  cond_o = !ops_equal;
            CT_BR_GEZ: cond_o = !rs_neg;
            CT_BR_GTZ: cond_o = !rs_neg && !rs_zero;
            CT_BR_LEZ: cond_o = rs_neg || rs_zero;
            CT_BR_LTZ: cond_o = rs_neg;
            default:   is_branch_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit (top)
// Selects the next PC from sequential, register, region and branch targets.
// Raises taken, and produces the link-write request for linking jumps.
// An optional PC register (REG_PC = 1) loads next_pc_o on every clock.
// Assumes op_i is stable for the cycle and rst_n is synchronous, active low.
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          OFF_W       = 16,
    parameter int          TGT_W       = 26,
    parameter int          REGION_BITS = 28,
    parameter int          RIDX_W      = 5,
    parameter int          REG_PC      = 1,
    parameter logic [31:0] RESET_PC    = 32'hBFC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [3:0]        op_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [TGT_W-1:0]  target_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_rd_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic [XLEN-1:0]   pc_reg_o
);
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'((1 << RIDX_W) - 1);

    ct_op_e          op;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] rgn_tgt;
    logic            is_branch;
    logic            br_cond;

    // Interpret the raw opcode bits as the shared enum.
    always_comb op = ct_op_e'(op_i);

    npc_target_gen #(
        .XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W), .REGION_BITS(REGION_BITS)
    ) i_tgt (
        .pc_i      (pc_i),
        .offset_i  (offset_i),
        .target_i  (target_i),
        .seq_pc_o  (seq_pc),
        .br_tgt_o  (br_tgt),
        .rgn_tgt_o (rgn_tgt)
    );

    npc_cond_eval #(.XLEN(XLEN)) i_cond (
        .op_i        (op),
        .rs_val_i    (rs_val_i),
        .rt_val_i    (rt_val_i),
        .is_branch_o (is_branch),
        .cond_o      (br_cond)
    );

    // Select the next PC, taken flag and link request per opcode.
    always_comb begin
        next_pc_o  = seq_pc;
        taken_o    = 1'b0;
        link_we_o  = 1'b0;
        link_rd_o  = '0;
        link_val_o = seq_pc;
        unique case (op)
            CT_JREG: begin
                next_pc_o = rs_val_i;
                taken_o   = 1'b1;
            end
            CT_JREGION: begin
                next_pc_o = rgn_tgt;
                taken_o   = 1'b1;
            end
            CT_JREG_LINK: begin
                next_pc_o = rs_val_i;
                taken_o   = 1'b1;
                link_we_o = 1'b1;
                link_rd_o = rd_i;
            end
            CT_JRGN_LINK: begin
                next_pc_o = rgn_tgt;
                taken_o   = 1'b1;
                link_we_o = 1'b1;
                link_rd_o = LINK_REG;
            end
            default: begin
                if (is_branch && br_cond) begin
                    next_pc_o = br_tgt;
                    taken_o   = 1'b1;
                end
            end
        endcase
    end

    // Assertions guarding the selection logic.
    a_r9_idle_seq: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> (next_pc_o == pc_i + XLEN'(4)));
    a_r8_link_is_jump: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (taken_o && !is_branch && link_val_o == pc_i + XLEN'(4)));
    a_r8_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !link_we_o |-> (link_rd_o == '0));
    a_r2_region_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CT_JREGION) |-> (next_pc_o[XLEN-1:REGION_BITS] == seq_pc[XLEN-1:REGION_BITS]));
    a_r6_eq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CT_BR_EQ && rs_val_i == rt_val_i) |-> (taken_o && next_pc_o == br_tgt));
    a_r7_ltz_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CT_BR_LTZ) |-> (taken_o == rs_val_i[XLEN-1]));

    // Optional PC register or pass-through.
    generate
        if (REG_PC != 0) begin : g_pc_reg
            logic [XLEN-1:0] pc_q;
            logic            ran_q;

            // Load the selected PC each clock; boot address under reset.
            always_ff @(posedge clk) begin
                if (!rst_n) pc_q <= XLEN'(RESET_PC);
                else        pc_q <= next_pc_o;
            end

            // Marks that at least one cycle has run out of reset.
            always_ff @(posedge clk) begin
                if (!rst_n) ran_q <= 1'b0;
                else        ran_q <= 1'b1;
            end

            always_comb pc_reg_o = pc_q;

            a_r10_pc_follow: assert property (@(posedge clk) disable iff (!rst_n)
                ran_q |-> (pc_reg_o == $past(next_pc_o)));
        end else begin : g_pc_pass
            // No register: the output follows the combinational result.
            always_comb pc_reg_o = next_pc_o;
        end
    endgenerate

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0, rs_val_i = '0, rt_val_i = '0;
    logic [3:0]  op_i = '0;
    logic [4:0]  rd_i = '0;
    logic [15:0] offset_i = '0;
    logic [25:0] target_i = '0;
    logic [31:0] next_pc_o, link_val_o, pc_reg_o;
    logic        taken_o, link_we_o;
    logic [4:0]  link_rd_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .op_i(op_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .rd_i(rd_i),
        .offset_i(offset_i), .target_i(target_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .link_val_o(link_val_o), .pc_reg_o(pc_reg_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one operation, check combinational outputs, then the PC register.
    task automatic run_op(input string req, input logic [3:0] op,
                          input logic [31:0] pc, input logic [31:0] rs,
                          input logic [31:0] rt, input logic [4:0] rd,
                          input logic [15:0] off, input logic [25:0] tgt,
                          input logic [31:0] exp_pc, input logic exp_taken,
                          input logic exp_we, input logic [4:0] exp_rd);
        @(negedge clk);
        op_i = op; pc_i = pc; rs_val_i = rs; rt_val_i = rt;
        rd_i = rd; offset_i = off; target_i = tgt;
        #2;
        check(req, "next_pc", next_pc_o, exp_pc);
        check(req, "taken", {31'd0, taken_o}, {31'd0, exp_taken});
        check(req, "link_we", {31'd0, link_we_o}, {31'd0, exp_we});
        check(req, "link_rd", {27'd0, link_rd_o}, {27'd0, exp_rd});
        if (exp_we) check(req, "link_val", link_val_o, pc + 32'd4);
        @(posedge clk); #2;
        check("R10", "pc_reg follows", pc_reg_o, exp_pc);
    endtask

    function automatic logic [31:0] br_target(input logic [31:0] pc, input logic [15:0] off);
        logic signed [31:0] d;
        d = 32'(signed'(off)) * 4;
        return pc + 32'd4 + d;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 check("R10", "reset pc", pc_reg_o, 32'hBFC0_0000);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_jumps();
        run_op("R1", 4'd1, 32'h0040_0100, 32'h1234_5678, 32'h0, 5'd7, 16'h0, 26'h0,
               32'h1234_5678, 1, 0, 5'd0);
        // R2: PC+4 crosses into the next 256 MB region.
        run_op("R2", 4'd2, 32'h0FFF_FFFC, 32'h0, 32'h0, 5'd0, 16'h0, 26'h3AB_CDEF,
               {4'h1, 26'h3AB_CDEF, 2'b00}, 1, 0, 5'd0);
        run_op("R2", 4'd2, 32'h7000_0010, 32'h0, 32'h0, 5'd0, 16'h0, 26'h000_0001,
               32'h7000_0004, 1, 0, 5'd0);
        run_op("R3", 4'd3, 32'h0040_2000, 32'h8000_0040, 32'h0, 5'd9, 16'h0, 26'h0,
               32'h8000_0040, 1, 1, 5'd9);
        run_op("R4", 4'd4, 32'hAFFF_FFFC, 32'h0, 32'h0, 5'd3, 16'h0, 26'h155_5555,
               {4'hB, 26'h155_5555, 2'b00}, 1, 1, 5'd31);
    endtask

    task automatic t_equality();
        run_op("R6", 4'd5, 32'h0000_1000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd4, 16'h0010, 26'h0,
               br_target(32'h0000_1000, 16'h0010), 1, 0, 5'd0);
        run_op("R6", 4'd5, 32'h0000_1000, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 5'd4, 16'h0010, 26'h0,
               32'h0000_1004, 0, 0, 5'd0);
        run_op("R6", 4'd6, 32'h0000_2000, 32'h1, 32'h2, 5'd0, 16'hFFFE, 26'h0,
               32'h0000_1FFC, 1, 0, 5'd0);
        run_op("R6", 4'd6, 32'h0000_2000, 32'h5, 32'h5, 5'd0, 16'hFFFE, 26'h0,
               32'h0000_2004, 0, 0, 5'd0);
        // R5: most negative displacement.
        run_op("R5", 4'd5, 32'h0010_0000, 32'h0, 32'h0, 5'd0, 16'h8000, 26'h0,
               32'h000E_0004, 1, 0, 5'd0);
        run_op("R5", 4'd5, 32'h0010_0000, 32'h0, 32'h0, 5'd0, 16'h7FFF, 26'h0,
               32'h0012_0000, 1, 0, 5'd0);
    endtask

    task automatic t_zero_cmp();
        logic [31:0] vals [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
        for (int op = 7; op <= 10; op++) begin
            for (int i = 0; i < 5; i++) begin
                logic signed [31:0] v;
                logic tk;
                v = signed'(vals[i]);
                case (op)
                    7:  tk = (v >= 0);
                    8:  tk = (v > 0);
                    9:  tk = (v <= 0);
                    default: tk = (v < 0);
                endcase
                run_op("R7", 4'(op), 32'h0040_0000, vals[i], 32'h0, 5'd0, 16'h0003, 26'h0,
                       tk ? 32'h0040_0010 : 32'h0040_0004, tk, 0, 5'd0);
            end
        end
    endtask

    task automatic t_idle();
        // R9/R8: operands that would satisfy a branch or link must do nothing.
        run_op("R9", 4'd0, 32'h0000_3000, 32'h0, 32'h0, 5'd12, 16'h0040, 26'h3FF_FFFF,
               32'h0000_3004, 0, 0, 5'd0);
        run_op("R9", 4'd13, 32'h0000_3000, 32'h0, 32'h0, 5'd12, 16'h0040, 26'h3FF_FFFF,
               32'h0000_3004, 0, 0, 5'd0);
        run_op("R8", 4'd1, 32'h0000_3000, 32'h44, 32'h0, 5'd12, 16'h0, 26'h0,
               32'h0000_0044, 1, 0, 5'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_jumps();
                t_equality();
                t_zero_cmp();
                t_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule